// File: doc/BRIEF.md
# Asymmetric Dual-Port RAM with Byte Parity

This block is a synchronous dual-port memory holding 16,384 data bits and 2,048 parity bits behind two independent access ports, A and B. Each port picks its own total width through a parameter, one of 1, 2, 4, 9, 18 or 36. The 9, 18 and 36 widths split into 8, 16 or 32 data bits plus 1, 2 or 4 parity bits. The narrower widths carry data only. A narrower data width gives a port more address bits, so that every width covers the same store.

When the two widths differ, the block matches them with no extra logic at the user's side. A wide word spans several consecutive narrow addresses, and the lowest narrow address occupies the least significant slice of the wide word. Parity bit i always travels with data byte i. A byte written with its parity through one width reads back with the same parity through any other parity-capable width.

Both ports share one clock. A read returns its data one cycle after the enabled access. An enabled write also places the written word on that port's own output in the same cycle.

Top module: `dpr_asym_ram`

## Requirements
- R1: A port of total width W has data width D and parity width P as follows: 1→1/0, 2→2/0, 4→4/0, 9→8/1, 18→16/2, 36→32/4. Its address is 14 − log2(D) bits wide, and every address up to the highest reaches a distinct location.
- R2: An enabled read (en=1, we=0) presents the addressed word on the data and parity outputs after the next rising clock edge, and not before it.
- R3: An enabled write (en=1, we=1) stores the word and presents the written data and parity on the same port's outputs after that same edge.
- R4: Data bit k of narrow address a is memory bit a·D+k. Consecutive narrow words therefore pack into a wider word from the least significant end upward.
- R5: A word written through a wide port reads back as its consecutive D-bit slices through the narrower port, lowest address first.
- R6: Parity bit k of address a is parity bit a·P+k, so parity bit i stays with data byte i across the 9, 18 and 36 widths.
- R7: On a width without parity, the parity input is ignored, the parity output reads 0, and writes leave the stored parity bits unchanged.
- R8: While rst_ni is low, all data and parity outputs are 0. Reset does not alter the stored contents.
- R9: With en=0 a port neither writes nor changes its outputs, whatever we, address and data do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock shared by both ports |
| rst_ni | input | 1 | Asynchronous active-low reset of the output registers |
| en_a_i | input | 1 | Port A access enable |
| we_a_i | input | 1 | Port A write enable |
| addr_a_i | input | 14−log2(D_A) | Port A address |
| din_a_i | input | D_A | Port A write data |
| pin_a_i | input | max(1,P_A) | Port A write parity |
| dout_a_o | output | D_A | Port A read data |
| pout_a_o | output | max(1,P_A) | Port A read parity |
| en_b_i | input | 1 | Port B access enable |
| we_b_i | input | 1 | Port B write enable |
| addr_b_i | input | 14−log2(D_B) | Port B address |
| din_b_i | input | D_B | Port B write data |
| pin_b_i | input | max(1,P_B) | Port B write parity |
| dout_b_o | output | D_B | Port B read data |
| pout_b_o | output | max(1,P_B) | Port B read parity |

## Verification
The hardest case to reach is a pair of port widths other than the one under test. The widths are fixed when the block is elaborated, and the harm a no-parity port can do to stored parity only shows when a parity-capable width on the other port reads back the same bytes. The bench therefore builds a matrix of 36 instances, one for every ordered pair of widths. Each instance writes through one port and reads the overlapping addresses through the other, in both directions. A final pass overwrites, through port A, the bytes that port B wrote with parity, and then reads them again through port B. Every read is compared against a bit-level model that tracks which bits are known.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
  localparam int ROWS   = 512;
  localparam int ROW_AW = $clog2(ROWS);
  localparam int ROW_DW = 32;
  localparam int ROW_PW = ROW_DW / 8;

  function automatic int data_w(input int w);
    return (w >= 9) ? w - w / 9 : w;
  endfunction

  function automatic int par_w(input int w);
    return (w >= 9) ? w / 9 : 0;
  endfunction

  function automatic int pin_w(input int w);
    return (par_w(w) > 0) ? par_w(w) : 1;
  endfunction

  function automatic int lane_w(input int w);
    return $clog2(ROW_DW / data_w(w));
  endfunction

  function automatic int addr_w(input int w);
    return ROW_AW + lane_w(w);
  endfunction
endpackage

// File: rtl/dpr_addr_split.sv
module dpr_addr_split import dpr_pkg::*; #(
  parameter int WIDTH = 36
) (
  input  logic [addr_w(WIDTH)-1:0]                          addr_i,
  output logic [ROW_AW-1:0]                                 row_o,
  output logic [((lane_w(WIDTH) > 0) ? lane_w(WIDTH) : 1)-1:0] lane_o
);
  localparam int AW = addr_w(WIDTH);
  localparam int LW = lane_w(WIDTH);

  if (LW == 0) begin : g_full
    assign row_o  = addr_i;
    assign lane_o = '0;
  end else begin : g_lane
    // low address bits pick the slice inside a row
    assign row_o  = addr_i[AW-1:LW];
    assign lane_o = addr_i[LW-1:0];
  end
endmodule

// File: rtl/dpr_port.sv
module dpr_port import dpr_pkg::*; #(
  parameter int WIDTH = 36
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     en_i,
  input  logic                     we_i,
  input  logic [addr_w(WIDTH)-1:0] addr_i,
  input  logic [data_w(WIDTH)-1:0] din_i,
  input  logic [pin_w(WIDTH)-1:0]  pin_i,
  output logic [data_w(WIDTH)-1:0] dout_o,
  output logic [pin_w(WIDTH)-1:0]  pout_o,
  output logic [ROW_AW-1:0]        row_o,
  output logic                     wr_o,
  output logic [ROW_DW-1:0]        wr_dmask_o,
  output logic [ROW_DW-1:0]        wr_dat_o,
  output logic [ROW_PW-1:0]        wr_pmask_o,
  output logic [ROW_PW-1:0]        wr_par_o,
  input  logic [ROW_DW-1:0]        rd_dat_i,
  input  logic [ROW_PW-1:0]        rd_par_i
);
  localparam int DW  = data_w(WIDTH);
  localparam int PW  = par_w(WIDTH);
  localparam int LW  = lane_w(WIDTH);
  localparam int LWP = (LW > 0) ? LW : 1;

  logic [LWP-1:0] lane;
  logic [DW-1:0]  rd_slice;
  int             sh_d;

  dpr_addr_split #(.WIDTH(WIDTH)) u_split (
    .addr_i (addr_i),
    .row_o  (row_o),
    .lane_o (lane)
  );

  assign wr_o = en_i & we_i;

  always_comb begin
    sh_d       = int'(lane) * DW;
    wr_dmask_o = ROW_DW'({DW{1'b1}}) << sh_d;
    wr_dat_o   = ROW_DW'(din_i) << sh_d;
    rd_slice   = DW'(rd_dat_i >> sh_d);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   dout_o <= '0;
    else if (en_i) dout_o <= we_i ? din_i : rd_slice;
  end

  if (PW > 0) begin : g_par
    logic [PW-1:0] rd_pslice;
    int            sh_p;

    always_comb begin
      sh_p       = int'(lane) * PW;
      wr_pmask_o = ROW_PW'({PW{1'b1}}) << sh_p;
      wr_par_o   = ROW_PW'(pin_i) << sh_p;
      rd_pslice  = PW'(rd_par_i >> sh_p);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   pout_o <= '0;
      else if (en_i) pout_o <= we_i ? pin_i : rd_pslice;
    end
  end else begin : g_nopar
    logic unused_par;
    assign unused_par = ^{pin_i, rd_par_i};
    assign wr_pmask_o = '0;
    assign wr_par_o   = '0;
    assign pout_o     = '0;
  end
endmodule

// File: rtl/dpr_store.sv
module dpr_store import dpr_pkg::*; (
  input  logic              clk_i,
  input  logic              wr_a_i,
  input  logic [ROW_AW-1:0] row_a_i,
  input  logic [ROW_DW-1:0] dmask_a_i,
  input  logic [ROW_DW-1:0] dat_a_i,
  input  logic [ROW_PW-1:0] pmask_a_i,
  input  logic [ROW_PW-1:0] par_a_i,
  input  logic              wr_b_i,
  input  logic [ROW_AW-1:0] row_b_i,
  input  logic [ROW_DW-1:0] dmask_b_i,
  input  logic [ROW_DW-1:0] dat_b_i,
  input  logic [ROW_PW-1:0] pmask_b_i,
  input  logic [ROW_PW-1:0] par_b_i,
  output logic [ROW_DW-1:0] rd_dat_a_o,
  output logic [ROW_PW-1:0] rd_par_a_o,
  output logic [ROW_DW-1:0] rd_dat_b_o,
  output logic [ROW_PW-1:0] rd_par_b_o
);
  logic [ROW_DW-1:0] mem_d [ROWS];
  logic [ROW_PW-1:0] mem_p [ROWS];

  // bitwise masked writes; overlapping bits from both ports are undefined
  always_ff @(posedge clk_i) begin
    if (wr_a_i) begin
      for (int k = 0; k < ROW_DW; k++)
        if (dmask_a_i[k]) mem_d[row_a_i][k] <= dat_a_i[k];
      for (int k = 0; k < ROW_PW; k++)
        if (pmask_a_i[k]) mem_p[row_a_i][k] <= par_a_i[k];
    end
    if (wr_b_i) begin
      for (int k = 0; k < ROW_DW; k++)
        if (dmask_b_i[k]) mem_d[row_b_i][k] <= dat_b_i[k];
      for (int k = 0; k < ROW_PW; k++)
        if (pmask_b_i[k]) mem_p[row_b_i][k] <= par_b_i[k];
    end
  end

  assign rd_dat_a_o = mem_d[row_a_i];
  assign rd_par_a_o = mem_p[row_a_i];
  assign rd_dat_b_o = mem_d[row_b_i];
  assign rd_par_b_o = mem_p[row_b_i];
endmodule

// File: rtl/dpr_asym_ram.sv
module dpr_asym_ram import dpr_pkg::*; #(
  parameter int WIDTH_A = 36,
  parameter int WIDTH_B = 9
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       en_a_i,
  input  logic                       we_a_i,
  input  logic [addr_w(WIDTH_A)-1:0] addr_a_i,
  input  logic [data_w(WIDTH_A)-1:0] din_a_i,
  input  logic [pin_w(WIDTH_A)-1:0]  pin_a_i,
  output logic [data_w(WIDTH_A)-1:0] dout_a_o,
  output logic [pin_w(WIDTH_A)-1:0]  pout_a_o,
  input  logic                       en_b_i,
  input  logic                       we_b_i,
  input  logic [addr_w(WIDTH_B)-1:0] addr_b_i,
  input  logic [data_w(WIDTH_B)-1:0] din_b_i,
  input  logic [pin_w(WIDTH_B)-1:0]  pin_b_i,
  output logic [data_w(WIDTH_B)-1:0] dout_b_o,
  output logic [pin_w(WIDTH_B)-1:0]  pout_b_o
);
  logic [ROW_AW-1:0] row_a, row_b;
  logic              wr_a, wr_b;
  logic [ROW_DW-1:0] dmask_a, dat_a, dmask_b, dat_b, rd_dat_a, rd_dat_b;
  logic [ROW_PW-1:0] pmask_a, par_a, pmask_b, par_b, rd_par_a, rd_par_b;

  dpr_port #(.WIDTH(WIDTH_A)) u_port_a (
    .clk_i, .rst_ni,
    .en_i (en_a_i), .we_i (we_a_i), .addr_i (addr_a_i),
    .din_i (din_a_i), .pin_i (pin_a_i), .dout_o (dout_a_o), .pout_o (pout_a_o),
    .row_o (row_a), .wr_o (wr_a), .wr_dmask_o (dmask_a), .wr_dat_o (dat_a),
    .wr_pmask_o (pmask_a), .wr_par_o (par_a),
    .rd_dat_i (rd_dat_a), .rd_par_i (rd_par_a)
  );

  dpr_port #(.WIDTH(WIDTH_B)) u_port_b (
    .clk_i, .rst_ni,
    .en_i (en_b_i), .we_i (we_b_i), .addr_i (addr_b_i),
    .din_i (din_b_i), .pin_i (pin_b_i), .dout_o (dout_b_o), .pout_o (pout_b_o),
    .row_o (row_b), .wr_o (wr_b), .wr_dmask_o (dmask_b), .wr_dat_o (dat_b),
    .wr_pmask_o (pmask_b), .wr_par_o (par_b),
    .rd_dat_i (rd_dat_b), .rd_par_i (rd_par_b)
  );

  dpr_store u_store (
    .clk_i,
    .wr_a_i (wr_a), .row_a_i (row_a), .dmask_a_i (dmask_a), .dat_a_i (dat_a),
    .pmask_a_i (pmask_a), .par_a_i (par_a),
    .wr_b_i (wr_b), .row_b_i (row_b), .dmask_b_i (dmask_b), .dat_b_i (dat_b),
    .pmask_b_i (pmask_b), .par_b_i (par_b),
    .rd_dat_a_o (rd_dat_a), .rd_par_a_o (rd_par_a),
    .rd_dat_b_o (rd_dat_b), .rd_par_b_o (rd_par_b)
  );
endmodule

// File: rtl/dpr_asym_ram_chk.sv
module dpr_asym_ram_chk import dpr_pkg::*; #(
  parameter int WIDTH_A = 36,
  parameter int WIDTH_B = 9
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       en_a_i,
  input logic                       we_a_i,
  input logic [addr_w(WIDTH_A)-1:0] addr_a_i,
  input logic [data_w(WIDTH_A)-1:0] din_a_i,
  input logic [pin_w(WIDTH_A)-1:0]  pin_a_i,
  input logic [data_w(WIDTH_A)-1:0] dout_a_o,
  input logic [pin_w(WIDTH_A)-1:0]  pout_a_o,
  input logic                       en_b_i,
  input logic                       we_b_i,
  input logic [addr_w(WIDTH_B)-1:0] addr_b_i,
  input logic [data_w(WIDTH_B)-1:0] din_b_i,
  input logic [pin_w(WIDTH_B)-1:0]  pin_b_i,
  input logic [data_w(WIDTH_B)-1:0] dout_b_o,
  input logic [pin_w(WIDTH_B)-1:0]  pout_b_o
);
  logic unused_chk;
  assign unused_chk = ^{addr_a_i, addr_b_i};

  assert_rst_a_R8: assert property (@(posedge clk_i)
    !rst_ni |-> (dout_a_o == '0 && pout_a_o == '0));
  assert_rst_b_R8: assert property (@(posedge clk_i)
    !rst_ni |-> (dout_b_o == '0 && pout_b_o == '0));

  assert_wfirst_a_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_a_i && we_a_i) |=> dout_a_o == $past(din_a_i));
  assert_wfirst_b_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_b_i && we_b_i) |=> dout_b_o == $past(din_b_i));

  assert_hold_a_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_a_i |=> ($stable(dout_a_o) && $stable(pout_a_o)));
  assert_hold_b_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_b_i |=> ($stable(dout_b_o) && $stable(pout_b_o)));

  if (par_w(WIDTH_A) > 0) begin : g_pa
    assert_pwfirst_a_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_a_i && we_a_i) |=> pout_a_o == $past(pin_a_i));
  end
  if (par_w(WIDTH_B) > 0) begin : g_pb
    assert_pwfirst_b_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_b_i && we_b_i) |=> pout_b_o == $past(pin_b_i));
  end
endmodule

bind dpr_asym_ram dpr_asym_ram_chk #(.WIDTH_A(WIDTH_A), .WIDTH_B(WIDTH_B)) i_chk (.*);

// File: tb/test_dpr_asym_ram.sv
`timescale 1ns/1ps
module test_dpr_asym_ram;
  import dpr_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  int   n_checks = 0;
  int   n_fail = 0;
  int   cells_left = 36;

  always #2.5 clk = ~clk;

  // main instance: x36 on A, x9 on B
  logic        en_a = 0, we_a = 0, en_b = 0, we_b = 0;
  logic [8:0]  addr_a = '0;
  logic [31:0] din_a = '0, dout_a;
  logic [3:0]  pin_a = '0, pout_a;
  logic [10:0] addr_b = '0;
  logic [7:0]  din_b = '0, dout_b;
  logic [0:0]  pin_b = '0, pout_b;

  dpr_asym_ram #(.WIDTH_A(36), .WIDTH_B(9)) i_dpr_asym_ram (
    .clk_i (clk), .rst_ni (rst_n),
    .en_a_i (en_a), .we_a_i (we_a), .addr_a_i (addr_a), .din_a_i (din_a),
    .pin_a_i (pin_a), .dout_a_o (dout_a), .pout_a_o (pout_a),
    .en_b_i (en_b), .we_b_i (we_b), .addr_b_i (addr_b), .din_b_i (din_b),
    .pin_b_i (pin_b), .dout_b_o (dout_b), .pout_b_o (pout_b)
  );

  task automatic report;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic a_wr(input int a, input logic [31:0] d, input logic [3:0] p);
    @(negedge clk); en_a = 1; we_a = 1; addr_a = 9'(a); din_a = d; pin_a = p;
    @(negedge clk); en_a = 0; we_a = 0;
  endtask
  task automatic a_rd(input int a);
    @(negedge clk); en_a = 1; we_a = 0; addr_a = 9'(a);
    @(negedge clk); en_a = 0;
  endtask
  task automatic b_wr(input int a, input logic [7:0] d, input logic p);
    @(negedge clk); en_b = 1; we_b = 1; addr_b = 11'(a); din_b = d; pin_b = p;
    @(negedge clk); en_b = 0; we_b = 0;
  endtask
  task automatic b_rd(input int a);
    @(negedge clk); en_b = 1; we_b = 0; addr_b = 11'(a);
    @(negedge clk); en_b = 0;
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R8 reset dout_a", dout_a, 0);
    chk("R8 reset pout_a", 32'(pout_a), 0);
    chk("R8 reset dout_b", 32'(dout_b), 0);
    chk("R8 reset pout_b", 32'(pout_b), 0);
    rst_n = 1'b1;
  endtask

  task automatic t_split;
    a_wr(3, 32'hA1B2_C3D4, 4'b1010);
    for (int i = 0; i < 4; i++) begin
      b_rd(12 + i);
      chk("R5 wide split byte", 32'(dout_b), 32'((32'hA1B2_C3D4 >> (8 * i)) & 32'hFF));
      chk("R6 parity follows byte", 32'(pout_b), 32'((4'b1010 >> i) & 4'b1));
    end
  endtask

  task automatic t_pack;
    logic [7:0] bytes [4];
    logic       par [4];
    bytes = '{8'h11, 8'h22, 8'h33, 8'h44};
    par = '{1'b1, 1'b0, 1'b0, 1'b1};
    for (int i = 0; i < 4; i++) b_wr(40 + i, bytes[i], par[i]);
    a_rd(10);
    chk("R4 narrow pack lsb first", dout_a, 32'h4433_2211);
    chk("R6 packed parity", 32'(pout_a), 32'h9);
  endtask

  task automatic t_top;
    b_wr(2047, 8'h5A, 1'b1);
    a_rd(511);
    chk("R1 top address data", 32'(dout_a[31:24]), 32'h5A);
    chk("R1 top address parity", 32'(pout_a[3]), 1);
    a_wr(0, 32'h0F1E_2D3C, 4'b0001);
    b_rd(0);
    chk("R1 bottom address data", 32'(dout_b), 32'h3C);
    chk("R1 bottom address parity", 32'(pout_b), 1);
  endtask

  task automatic t_wfirst;
    a_wr(7, 32'hCAFE_0123, 4'h5);
    chk("R3 write-first A data", dout_a, 32'hCAFE_0123);
    chk("R3 write-first A parity", 32'(pout_a), 5);
    b_wr(100, 8'h3C, 1'b0);
    chk("R3 write-first B data", 32'(dout_b), 32'h3C);
  endtask

  task automatic t_latency;
    a_rd(3);
    chk("R2 read data", dout_a, 32'hA1B2_C3D4);
    @(negedge clk); en_a = 1; we_a = 0; addr_a = 9'd7;
    #2;
    chk("R2 no early update", dout_a, 32'hA1B2_C3D4);
    @(negedge clk); en_a = 0;
    chk("R2 one-cycle read", dout_a, 32'hCAFE_0123);
  endtask

  task automatic t_hold;
    @(negedge clk); en_a = 0; we_a = 1; addr_a = 9'd7; din_a = 32'hFFFF_FFFF; pin_a = 4'hF;
    @(negedge clk);
    chk("R9 disabled holds output", dout_a, 32'hCAFE_0123);
    we_a = 0;
    a_rd(3);
    a_rd(7);
    chk("R9 disabled no write", dout_a, 32'hCAFE_0123);
    chk("R9 disabled no parity write", 32'(pout_a), 5);
  endtask

  task automatic t_reset_mid;
    @(negedge clk); rst_n = 1'b0;
    #1;
    chk("R8 async clear dout_a", dout_a, 0);
    chk("R8 async clear dout_b", 32'(dout_b), 0);
    @(negedge clk); rst_n = 1'b1;
    a_rd(7);
    chk("R8 contents kept", dout_a, 32'hCAFE_0123);
  endtask

  initial begin
    t_reset;
    t_split;
    t_pack;
    t_top;
    t_wfirst;
    t_latency;
    t_hold;
    wait (cells_left == 0);
    t_reset_mid;
    report;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R2 watchdog: got timeout exp completion");
    report;
  end

  // width-pair matrix: every ordered pair of port widths
  localparam int WL [6] = '{1, 2, 4, 9, 18, 36};

  for (genvar gi = 0; gi < 6; gi++) begin : g_a
    for (genvar gj = 0; gj < 6; gj++) begin : g_b
      localparam int WA = WL[gi];
      localparam int WB = WL[gj];
      localparam int DA = data_w(WA), PA = par_w(WA), QA = pin_w(WA), AA = addr_w(WA);
      localparam int DB = data_w(WB), PB = par_w(WB), QB = pin_w(WB), AB = addr_w(WB);

      logic          c_en_a = 0, c_we_a = 0, c_en_b = 0, c_we_b = 0;
      logic [AA-1:0] ad_a = '0;
      logic [DA-1:0] di_a = '0, do_a;
      logic [QA-1:0] pi_a = '0, po_a;
      logic [AB-1:0] ad_b = '0;
      logic [DB-1:0] di_b = '0, do_b;
      logic [QB-1:0] pi_b = '0, po_b;
      bit m_d [16384];
      bit m_k [16384];
      bit m_p [2048];
      bit m_pk [2048];

      dpr_asym_ram #(.WIDTH_A(WA), .WIDTH_B(WB)) u_cell (
        .clk_i (clk), .rst_ni (rst_n),
        .en_a_i (c_en_a), .we_a_i (c_we_a), .addr_a_i (ad_a), .din_a_i (di_a),
        .pin_a_i (pi_a), .dout_a_o (do_a), .pout_a_o (po_a),
        .en_b_i (c_en_b), .we_b_i (c_we_b), .addr_b_i (ad_b), .din_b_i (di_b),
        .pin_b_i (pi_b), .dout_b_o (do_b), .pout_b_o (po_b)
      );

      task automatic wr_a(input int a);
        logic [DA-1:0] d;
        logic [QA-1:0] p;
        d = DA'($urandom); p = QA'($urandom);
        @(negedge clk); c_en_a = 1; c_we_a = 1; ad_a = AA'(a); di_a = d; pi_a = p;
        @(negedge clk); c_en_a = 0; c_we_a = 0;
        for (int k = 0; k < DA; k++) begin m_d[a*DA+k] = d[k]; m_k[a*DA+k] = 1'b1; end
        for (int k = 0; k < PA; k++) begin m_p[a*PA+k] = p[k]; m_pk[a*PA+k] = 1'b1; end
      endtask

      task automatic wr_b(input int a);
        logic [DB-1:0] d;
        logic [QB-1:0] p;
        d = DB'($urandom); p = QB'($urandom);
        @(negedge clk); c_en_b = 1; c_we_b = 1; ad_b = AB'(a); di_b = d; pi_b = p;
        @(negedge clk); c_en_b = 0; c_we_b = 0;
        for (int k = 0; k < DB; k++) begin m_d[a*DB+k] = d[k]; m_k[a*DB+k] = 1'b1; end
        for (int k = 0; k < PB; k++) begin m_p[a*PB+k] = p[k]; m_pk[a*PB+k] = 1'b1; end
      endtask

      task automatic rd_a(input int a);
        logic [DA-1:0] e, m;
        logic [QA-1:0] ep, mp;
        @(negedge clk); c_en_a = 1; c_we_a = 0; ad_a = AA'(a);
        @(negedge clk); c_en_a = 0;
        e = '0; m = '0; ep = '0; mp = (PA == 0) ? '1 : '0;
        for (int k = 0; k < DA; k++) begin e[k] = m_d[a*DA+k]; m[k] = m_k[a*DA+k]; end
        for (int k = 0; k < PA; k++) begin ep[k] = m_p[a*PA+k]; mp[k] = m_pk[a*PA+k]; end
        n_checks++;
        if (((do_a ^ e) & m) != '0 || ((po_a ^ ep) & mp) != '0) begin
          n_fail++;
          $display("FAIL R1 R4 R5 R6 R7 x%0d/x%0d port A addr %0d: got %h/%h exp %h/%h",
                   WA, WB, a, do_a & m, po_a & mp, e, ep);
        end
      endtask

      task automatic rd_b(input int a);
        logic [DB-1:0] e, m;
        logic [QB-1:0] ep, mp;
        @(negedge clk); c_en_b = 1; c_we_b = 0; ad_b = AB'(a);
        @(negedge clk); c_en_b = 0;
        e = '0; m = '0; ep = '0; mp = (PB == 0) ? '1 : '0;
        for (int k = 0; k < DB; k++) begin e[k] = m_d[a*DB+k]; m[k] = m_k[a*DB+k]; end
        for (int k = 0; k < PB; k++) begin ep[k] = m_p[a*PB+k]; mp[k] = m_pk[a*PB+k]; end
        n_checks++;
        if (((do_b ^ e) & m) != '0 || ((po_b ^ ep) & mp) != '0) begin
          n_fail++;
          $display("FAIL R1 R4 R5 R6 R7 x%0d/x%0d port B addr %0d: got %h/%h exp %h/%h",
                   WA, WB, a, do_b & m, po_b & mp, e, ep);
        end
      endtask

      initial begin
        int wa [6];
        int wb [6];
        wait (rst_n === 1'b1);
        repeat (2) @(negedge clk);
        for (int n = 0; n < 6; n++) begin
          wa[n] = (n == 0) ? 0 : (n == 1) ? (1 << AA) - 1 : int'($urandom % (1 << AA));
          wr_a(wa[n]);
        end
        for (int n = 0; n < 6; n++) begin
          rd_b((wa[n] * DA) / DB);
          rd_b(((wa[n] + 1) * DA - 1) / DB);
        end
        for (int n = 0; n < 6; n++) begin
          wb[n] = (n == 0) ? 0 : (n == 1) ? (1 << AB) - 1 : int'($urandom % (1 << AB));
          wr_b(wb[n]);
        end
        for (int n = 0; n < 6; n++) begin
          rd_a((wb[n] * DB) / DA);
          rd_a(((wb[n] + 1) * DB - 1) / DA);
        end
        // R7: overwrite B's bytes through A, B's parity must survive a no-parity A
        for (int n = 0; n < 6; n++) begin
          wr_a((wb[n] * DB) / DA);
          rd_b(wb[n]);
        end
        cells_left--;
      end
    end
  end
endmodule